// File: doc/BRIEF.md
# Masked Write RAM Port Controller

This block sits behind a narrow random access port whose four data pins do double duty: during a row cycle they first present a per-bit write mask and later carry write data in or read data out. Four active-low strobes (row, column, write and output enable) arrive asynchronously and are resampled on the system clock before any decision is taken. The controller keeps a 16-row by 16-column array of 4-bit words and performs masked writes and gated reads into it.

A row cycle opens when the row strobe falls, which latches the row address and, if the write strobe is already low at that moment, latches the data pins as the write mask. Otherwise the row cycle writes all four bits. A write takes place at whichever of the column-strobe or write-strobe falls comes last, and only the bits whose mask bit is 1 change. Reads are driven out while both the column strobe and the output enable are low, with a separate enable port marking when the pins would leave high impedance.

Top module: `mwram_port_ctrl`

## Requirements
- R1: After reset the data enable `dq_oe` is 0, the mask register holds all ones, and every stored word reads as 0.
- R2: Each strobe is resampled by a two-flop synchronizer; a strobe level presented before rising clock edge k takes effect at rising edge k+2 and its falling edge causes its action at edge k+2 as well.
- R3: A write changes only the bits whose captured mask bit is 1; bits with mask 0 keep their stored value.
- R4: At row-strobe fall the four data pins are captured as the mask when the write strobe is low; when it is high the mask is all ones (4'b1111).
- R5: The captured mask is discarded when the row strobe rises, so the next row cycle without a mask request writes all four bits.
- R6: Write data and column address are taken at the later of the column-strobe fall and the write-strobe fall within an open row cycle, and one such event writes exactly once.
- R7: The row address is taken at row-strobe fall and the column address at column-strobe fall; address pin changes after those falls do not move the access.
- R8: `dq_oe` is 1 only while a row cycle and a column cycle are open and both the column strobe and output enable are low; while it is 1, `dq_out` equals the word stored at the latched row and column.
- R9: `dq_oe` returns to 0 at the first rising edge of the column strobe or the output enable, whichever comes first.
- R10: Column and write strobe activity while the row strobe is high writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_stb_n | input | 1 | Write strobe, active low |
| oe_stb_n | input | 1 | Output enable strobe, active low |
| addr | input | ADDR_W (4) | Multiplexed row / column address |
| dq_in | input | DATA_W (4) | Data pins as seen by the block (mask or write data) |
| dq_out | output | DATA_W (4) | Read data toward the pins |
| dq_oe | output | 1 | High when the data pins are driven |

## Verification
The two functions that can share one clock cycle are the mask capture and the write itself: when the write strobe is already low at row fall, the mask is latched and a later column fall writes with it, so the masked merge depends on the mask taken a few cycles earlier from the same pins. The bench provokes this with early writes over known contents and then reads the word back, judging the merged bits against hand-computed values. The same reference model, run every clock, judges the read-enable window when the column strobe and output enable rise in either order.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

   // Resampled view of one active-low strobe.
   typedef struct packed {
      logic low;   // synchronized level is asserted
      logic fell;  // synchronized level went low this cycle
   } stb_view_t;

   // Strobe positions inside the packed strobe vector.
   localparam int S_ROW = 0;
   localparam int S_COL = 1;
   localparam int S_WR  = 2;
   localparam int S_OE  = 3;
   localparam int N_STB = 4;

   function automatic logic [7:0] merge_bits(input logic [7:0] old_w,
                                             input logic [7:0] new_w,
                                             input logic [7:0] sel);
      return (old_w & ~sel) | (new_w & sel);
   endfunction

endpackage

// File: rtl/mwram_strobe_sync.sv
module mwram_strobe_sync
   import mwram_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stb_n_i,
   output stb_view_t view_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mwram_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= stb_n_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign view_o.low  = ~chain_q[STAGES-1];
   assign view_o.fell = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/mwram_mask_reg.sv
module mwram_mask_reg #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,  // row cycle opens
   input  logic              request_i,  // write strobe low at that moment
   input  logic              clear_i,    // row cycle closes
   input  logic [DATA_W-1:0] pins_i,
   output logic [DATA_W-1:0] mask_o
);

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_o <= ALL_ONES;
      else if (capture_i)
         mask_o <= request_i ? pins_i : ALL_ONES;
      else if (clear_i)
         mask_o <= ALL_ONES;
   end

   // R5: a closed row cycle leaves no mask behind
   p_mask_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i && !capture_i |=> mask_o == ALL_ONES);

   // R4: without a request the row cycle writes every bit
   p_mask_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i && !request_i |=> mask_o == ALL_ONES);

endmodule

// File: rtl/mwram_array.sv
module mwram_array #(
   parameter int DATA_W = 4,
   parameter int ROW_AW = 4,
   parameter int COL_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ROW_AW-1:0] wrow_i,
   input  logic [COL_AW-1:0] wcol_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] wmask_i,
   input  logic [ROW_AW-1:0] rrow_i,
   input  logic [COL_AW-1:0] rcol_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int IDX_W = ROW_AW + COL_AW;
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (DATA_W > 8) begin : g_bad_width
         $error("mwram_array: DATA_W above 8 not supported by merge_bits");
      end
      if (DEPTH > 4096) begin : g_bad_depth
         $error("mwram_array: array too deep");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [IDX_W-1:0]  widx;
   logic [IDX_W-1:0]  ridx;
   logic [7:0]        merged;

   assign widx = {wrow_i, wcol_i};
   assign ridx = {rrow_i, rcol_i};

   assign merged = mwram_pkg::merge_bits(8'(mem_q[widx]), 8'(wdata_i), 8'(wmask_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[widx] <= merged[DATA_W-1:0];
      end
   end

   assign rdata_o = mem_q[ridx];

   // R3: masked-off bits of the addressed word survive the write
   p_masked_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> ((mem_q[$past(widx)] ^ $past(mem_q[widx])) & ~$past(wmask_i)) == '0);

endmodule

// File: rtl/mwram_port_ctrl.sv
module mwram_port_ctrl
   import mwram_pkg::*;
#(
   parameter  int DATA_W      = 4,
   parameter  int ROW_AW      = 4,
   parameter  int COL_AW      = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int ADDR_W      = (ROW_AW > COL_AW) ? ROW_AW : COL_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_stb_n,
   input  logic              col_stb_n,
   input  logic              wr_stb_n,
   input  logic              oe_stb_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   generate
      if (DATA_W < 1 || ROW_AW < 1 || COL_AW < 1) begin : g_bad_params
         $error("mwram_port_ctrl: widths must be positive");
      end
   endgenerate

   // ---- strobe resampling ----
   logic [N_STB-1:0] raw_n;
   stb_view_t        stb [N_STB];

   assign raw_n = {oe_stb_n, wr_stb_n, col_stb_n, row_stb_n};

   generate
      genvar gs;
      for (gs = 0; gs < N_STB; gs++) begin : g_sync
         mwram_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb_n_i(raw_n[gs]),
            .view_o (stb[gs])
         );
      end
   endgenerate

   logic unused_oe_fell;
   assign unused_oe_fell = stb[S_OE].fell;

   // ---- row / column cycle tracking ----
   logic              row_act_q, col_act_q;
   logic [ROW_AW-1:0] row_q;
   logic [COL_AW-1:0] col_q;
   logic              row_open, row_close, col_open, col_close;

   assign row_open  = stb[S_ROW].fell;
   assign row_close = row_act_q & ~stb[S_ROW].low;
   assign col_open  = row_act_q & stb[S_COL].fell;
   assign col_close = col_act_q & ~stb[S_COL].low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_act_q <= 1'b0;
         row_q     <= '0;
      end else if (row_open) begin
         row_act_q <= 1'b1;
         row_q     <= addr[ROW_AW-1:0];
      end else if (row_close) begin
         row_act_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_act_q <= 1'b0;
         col_q     <= '0;
      end else if (row_close) begin
         col_act_q <= 1'b0;
      end else if (col_open) begin
         col_act_q <= 1'b1;
         col_q     <= addr[COL_AW-1:0];
      end else if (col_close) begin
         col_act_q <= 1'b0;
      end
   end

   // ---- write event: later of the column and write falls ----
   logic              we;
   logic [COL_AW-1:0] wcol;
   logic [DATA_W-1:0] mask;

   assign we = (col_act_q | col_open) & stb[S_COL].low & stb[S_WR].low
             & (col_open | stb[S_WR].fell);
   assign wcol = col_open ? addr[COL_AW-1:0] : col_q;

   mwram_mask_reg #(.DATA_W(DATA_W)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture_i(row_open),
      .request_i(stb[S_WR].low),
      .clear_i  (row_close),
      .pins_i   (dq_in),
      .mask_o   (mask)
   );

   mwram_array #(.DATA_W(DATA_W), .ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (we),
      .wrow_i (row_q),
      .wcol_i (wcol),
      .wdata_i(dq_in),
      .wmask_i(mask),
      .rrow_i (row_q),
      .rcol_i (col_q),
      .rdata_o(dq_out)
   );

   // ---- read drive window ----
   assign dq_oe = row_act_q & col_act_q & stb[S_COL].low & stb[S_OE].low;

   // R10: nothing is written outside a row cycle
   p_no_write_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !row_act_q |-> !we);

   // R6: one strobe event yields a single write
   p_write_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);

   // R8: the pins are driven only inside a column cycle
   p_oe_in_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(col_open) || $past(col_act_q));

endmodule

// File: tb/mwram_port_ctrl_tb_top.sv
module mwram_port_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
   logic [3:0] addr = '0;
   logic [3:0] dq_in = '0;
   logic [3:0] dq_out;
   logic       dq_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   mwram_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .row_stb_n(row_n), .col_stb_n(col_n), .wr_stb_n(wr_n), .oe_stb_n(oe_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---- behavioural reference model, advanced every rising edge ----
   // sample bits: [0]=row [1]=col [2]=wr [3]=oe, 1 = strobe high
   logic [3:0] hist[$];
   logic [3:0] m_mem [256];
   logic [3:0] m_mask;
   bit         m_row, m_col;
   int         m_r, m_c;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = '{4'hF, 4'hF, 4'hF, 4'hF};
         foreach (m_mem[i]) m_mem[i] = '0;
         m_mask = 4'hF; m_row = 0; m_col = 0; m_r = 0; m_c = 0;
      end else begin
         logic [3:0] cur, old;
         bit rf, cf, wf, cl, we_m;
         int wc;
         hist.push_front({oe_n, wr_n, col_n, row_n});
         if (hist.size() > 4) void'(hist.pop_back());
         cur = hist[2]; old = hist[3];       // R2: two-stage resampling lag
         rf = old[0] & !cur[0];
         cf = old[1] & !cur[1];
         wf = old[2] & !cur[2];
         cl = m_row && cf;
         we_m = (m_col || cl) && !cur[1] && !cur[2] && (cl || wf);
         wc = cl ? int'(addr) : m_c;
         if (we_m)
            m_mem[m_r*16 + wc] = (m_mem[m_r*16 + wc] & ~m_mask) | (dq_in & m_mask);
         if (rf) begin
            m_row = 1; m_r = addr;
            m_mask = !cur[2] ? dq_in : 4'hF;
         end else if (m_row && cur[0]) begin
            m_row = 0; m_col = 0; m_mask = 4'hF;
         end
         if (m_row && !(!rf && cur[0])) begin
            if (cl) begin m_col = 1; m_c = addr; end
            else if (m_col && cur[1]) m_col = 0;
         end
      end
   end

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && hist.size() >= 2 && !done) begin
         bit exp_oe;
         exp_oe = m_row && m_col && !hist[1][1] && !hist[1][3];
         check(dq_oe == exp_oe, "R8 model dq_oe", dq_oe, exp_oe);
         if (exp_oe)
            check(dq_out == m_mem[m_r*16 + m_c], "R8 model dq_out",
                  dq_out, m_mem[m_r*16 + m_c]);
      end
   end

   task automatic step();
      repeat (4) @(negedge clk);
   endtask

   task automatic do_write(input int r, input int c, input logic [3:0] d,
                           input bit use_mask, input logic [3:0] msk, input bit late);
      dq_in = use_mask ? msk : 4'h0;
      wr_n  = use_mask ? 1'b0 : 1'b1;
      addr  = 4'(r); step();
      row_n = 0; step();
      addr  = 4'(c); dq_in = d;
      col_n = 0; step();
      if (late) begin wr_n = 0; step(); end
      wr_n = 1; col_n = 1; step();
      row_n = 1; step();
   endtask

   task automatic do_read(input int r, input int c, input logic [3:0] exp,
                          input bit col_first, input string tag);
      addr = 4'(r); step();
      row_n = 0; step();
      addr = 4'(c); col_n = 0; step();
      oe_n = 0; step();
      check(dq_oe == 1'b1, {tag, " enable"}, dq_oe, 1);
      check(dq_out == exp, {tag, " data"}, dq_out, exp);
      if (col_first) begin
         col_n = 1; step();
         check(dq_oe == 1'b0, "R9 release on column rise", dq_oe, 0);
         oe_n = 1; step();
      end else begin
         oe_n = 1; step();
         check(dq_oe == 1'b0, "R9 release on enable rise", dq_oe, 0);
         col_n = 1; step();
      end
      row_n = 1; step();
   endtask

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 100000 && !done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL R2 watchdog actual=%0d expected<%0d", wd, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check(dq_oe == 1'b0, "R1 dq_oe after reset", dq_oe, 0);
      do_read(0, 0, 4'h0, 0, "R1 zero word");
      do_read(15, 15, 4'h0, 1, "R1 corner word");

      // R2 timing: enable appears two edges after oe falls, not one
      addr = 4'd1; step(); row_n = 0; step();
      col_n = 0; step();
      oe_n = 0; @(negedge clk);
      check(dq_oe == 1'b0, "R2 one edge after enable", dq_oe, 0);
      @(negedge clk);
      check(dq_oe == 1'b1, "R2 two edges after enable", dq_oe, 1);
      oe_n = 1; col_n = 1; step(); row_n = 1; step();

      // R6 late write, R7 row/column taken at their falls
      do_write(3, 5, 4'hA, 0, 4'h0, 1);
      do_read(3, 5, 4'hA, 0, "R6 late write");

      // R3/R4 masked early write: old A, data 5, mask 0011 -> 9
      do_write(3, 5, 4'h5, 1, 4'b0011, 0);
      do_read(3, 5, 4'h9, 1, "R3 masked merge");

      // R5 next row cycle without request writes all bits
      do_write(3, 5, 4'h6, 0, 4'h0, 1);
      do_read(3, 5, 4'h6, 0, "R5 mask discarded");

      // R4 mask all ones through request, corner address
      do_write(15, 15, 4'hC, 1, 4'hF, 0);
      do_read(15, 15, 4'hC, 0, "R4 full mask");

      // R4 zero mask: nothing changes
      do_write(15, 15, 4'h3, 1, 4'h0, 0);
      do_read(15, 15, 4'hC, 1, "R4 empty mask");

      // R10 strobe activity with no row cycle
      addr = 4'd5; dq_in = 4'h0; step();
      col_n = 0; wr_n = 0; step();
      col_n = 1; wr_n = 1; step();
      do_read(3, 5, 4'h6, 0, "R10 idle strobes ignored");

      // R7 address change after column fall does not move the write
      addr = 4'd2; step(); row_n = 0; step();
      addr = 4'd7; dq_in = 4'h3; col_n = 0; step();
      addr = 4'd9; step();
      wr_n = 0; step();
      wr_n = 1; col_n = 1; step(); row_n = 1; step();
      do_read(2, 7, 4'h3, 0, "R7 latched column");
      do_read(2, 9, 4'h0, 1, "R7 other column untouched");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule